// File: doc/BRIEF.md
# Packed-Symbol Error Correction Applier

This block holds one flash page image in on-chip storage. The image is 2048 data bytes followed by 64 spare bytes, both in one linear byte space. After an external Reed-Solomon decoder has located the errors in a page, it hands this block up to four (symbol position, 12-bit error pattern) pairs. The block turns each pair into read-modify-write XOR updates of the stored bytes. Two 12-bit symbols pack into three bytes, so one symbol touches a whole byte and half of a neighbouring byte.

Symbol 0 is padded with four bits and carries only 8 data bits. The symbol at position 1365 spans the last data byte and the first spare byte. Positions beyond that fall inside the spare area, where the check symbols live. The block applies the corrections in order and stops at the first one it cannot apply. It then reports a fail flag and the number of symbols it corrected. A simple byte port loads the page before correction and reads it back afterwards.

Top module: `sym_corr_apply`

## Requirements
- R1: After reset, busy_o, done_o and fail_o are 0 and fixed_cnt_o is 0.
- R2: Outside a correction run, a host write stores host_wdata_i at linear address host_addr_i. Data bytes are at 0..2047 and spare bytes at 2048..2111. A host read returns the byte at host_addr_i on host_rdata_o one clock later.
- R3: For an odd position p, with b = floor(3p/2): byte b is XORed with pattern bits 11:4, and bits 7:4 of byte b+1 are XORed with pattern bits 3:0.
- R4: For an even nonzero position p, with b = floor(3p/2): bits 3:0 of byte b-1 are XORed with pattern bits 11:8, and byte b is XORed with pattern bits 7:0.
- R5: Position 0 XORs byte 0 with pattern bits 7:0. A pattern above 0xFF at position 0 is a failure and changes no byte.
- R6: Position 1365 XORs data byte 2047 with pattern bits 11:4 and bits 7:4 of spare byte 0 (address 2048) with pattern bits 3:0.
- R7: Positions 1366..1374 correct spare bytes under the odd and even rules of R3 and R4. A position above 1374 is a failure and changes no byte.
- R8: err_cnt_i gives the number of valid pairs, 0 to 4. Pair i sits at err_pos_i[11i+10:11i] and err_pat_i[12i+11:12i]. A count above 4 is a failure: no byte changes and fixed_cnt_o is 0.
- R9: Pairs are applied in index order, so later pairs see the results of earlier ones. At the first failing pair the run stops and no later pair is applied. fixed_cnt_o equals the number of pairs applied.
- R10: start_i taken while idle raises busy_o on the next clock. start_i while busy has no effect. When busy_o falls, done_o pulses for one cycle. fail_o and fixed_cnt_o then hold until the next accepted start.
- R11: Host writes presented while busy_o is 1 are ignored.
- R12: A run keeps busy_o high for one cycle per position check, plus two cycles per byte updated. The position checks are one per attempted pair plus one closing check when no pair fails. A count above 4 takes exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_we_i | input | 1 | Host byte write enable |
| host_addr_i | input | 12 | Host linear byte address |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Host read data, one cycle after address |
| start_i | input | 1 | Start a correction run |
| err_cnt_i | input | 3 | Number of valid pairs |
| err_pos_i | input | 44 | Four 11-bit symbol positions |
| err_pat_i | input | 48 | Four 12-bit error patterns |
| busy_o | output | 1 | Correction run in progress |
| done_o | output | 1 | One-cycle pulse at end of run |
| fail_o | output | 1 | Last run hit an uncorrectable pair |
| fixed_cnt_o | output | 3 | Symbols corrected by last run |

## Verification
The assertions check the run handshake on every cycle. An accepted start must raise busy, done must be a single-cycle pulse that follows busy, and the result flags must stay still while idle. A run that succeeds must report as many fixed symbols as it was given pairs, and an oversized count must yield a failure with zero fixed. The byte-level effects cannot be shown by a property and rely on the bench's scenarios. These effects are the odd, even and zero mappings, the straddling symbol, the spare-area positions, ordering between overlapping pairs, the stop-on-failure rule, the run length and the ignoring of host writes during a run. The bench compares the whole page image after each run.

// File: rtl/sym_corr_pkg.sv
package sym_corr_pkg;
  localparam int SYM_W  = 12;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CHECK,
    ST_RD,
    ST_WR
  } seq_state_e;
endpackage

// File: rtl/sym_corr_map.sv
module sym_corr_map
  import sym_corr_pkg::*;
#(
  parameter int POS_W    = 11,
  parameter int ADDR_W   = 12,
  parameter int LAST_POS = 1374
) (
  input  logic [POS_W-1:0]  pos_i,
  input  logic [SYM_W-1:0]  pat_i,
  output logic              bad_o,
  output logic              two_o,
  output logic [ADDR_W-1:0] addr0_o,
  output logic [BYTE_W-1:0] mask0_o,
  output logic [ADDR_W-1:0] addr1_o,
  output logic [BYTE_W-1:0] mask1_o
);
  localparam int TW = POS_W + 2;

  logic [TW-1:0]   tri3;
  logic [ADDR_W-1:0] base;
  logic            is_zero;
  logic            range_bad;

  assign tri3      = {2'b00, pos_i} + {1'b0, pos_i, 1'b0};
  assign base      = ADDR_W'(tri3 >> 1);
  assign is_zero   = (pos_i == '0);
  assign range_bad = (TW'(pos_i) > TW'(LAST_POS));

  always_comb begin
    bad_o   = range_bad;
    two_o   = 1'b1;
    addr0_o = base;
    mask0_o = pat_i[11:4];
    addr1_o = base + ADDR_W'(1);
    mask1_o = {pat_i[3:0], 4'h0};
    if (is_zero) begin
      // padded first symbol: only low byte is real data
      bad_o   = (pat_i[11:8] != 4'h0);
      two_o   = 1'b0;
      addr0_o = '0;
      mask0_o = pat_i[7:0];
      addr1_o = '0;
      mask1_o = '0;
    end else if (!pos_i[0]) begin
      addr0_o = base - ADDR_W'(1);
      mask0_o = {4'h0, pat_i[11:8]};
      addr1_o = base;
      mask1_o = pat_i[7:0];
    end
  end
endmodule

// File: rtl/sym_corr_ram.sv
module sym_corr_ram
  import sym_corr_pkg::*;
#(
  parameter int DEPTH  = 2112,
  parameter int ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [BYTE_W-1:0] rdata_o
);
  logic [BYTE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i && (waddr_i < ADDR_W'(DEPTH))) mem[waddr_i] <= wdata_i;
    if (raddr_i < ADDR_W'(DEPTH)) rdata_o <= mem[raddr_i];
    else                          rdata_o <= '0;
  end
endmodule

// File: rtl/sym_corr_seq.sv
module sym_corr_seq
  import sym_corr_pkg::*;
#(
  parameter int MAX_ERR  = 4,
  parameter int POS_W    = 11,
  parameter int ADDR_W   = 12,
  parameter int CNT_W    = 3,
  parameter int LAST_POS = 1374
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           start_i,
  input  logic [CNT_W-1:0]               cnt_i,
  input  logic [MAX_ERR-1:0][POS_W-1:0]  pos_i,
  input  logic [MAX_ERR-1:0][SYM_W-1:0]  pat_i,
  input  logic [BYTE_W-1:0]              rdata_i,
  output logic [ADDR_W-1:0]              raddr_o,
  output logic                           we_o,
  output logic [ADDR_W-1:0]              waddr_o,
  output logic [BYTE_W-1:0]              wdata_o,
  output logic                           busy_o,
  output logic                           done_o,
  output logic                           fail_o,
  output logic [CNT_W-1:0]               fixed_o
);
  localparam int SEL_W = $clog2(MAX_ERR);

  seq_state_e                  state_q;
  logic [MAX_ERR-1:0][POS_W-1:0] pos_q;
  logic [MAX_ERR-1:0][SYM_W-1:0] pat_q;
  logic [CNT_W-1:0]            cnt_q;
  logic [CNT_W-1:0]            idx_q;
  logic                        sel_q;
  logic                        two_q;
  logic [ADDR_W-1:0]           a0_q, a1_q;
  logic [BYTE_W-1:0]           m0_q, m1_q;
  logic                        done_q, fail_q;
  logic [CNT_W-1:0]            fixed_q;

  logic                        m_bad, m_two;
  logic [ADDR_W-1:0]           m_a0, m_a1;
  logic [BYTE_W-1:0]           m_m0, m_m1;
  logic [SEL_W-1:0]            cur;

  assign cur = idx_q[SEL_W-1:0];

  sym_corr_map #(
    .POS_W   (POS_W),
    .ADDR_W  (ADDR_W),
    .LAST_POS(LAST_POS)
  ) u_map (
    .pos_i  (pos_q[cur]),
    .pat_i  (pat_q[cur]),
    .bad_o  (m_bad),
    .two_o  (m_two),
    .addr0_o(m_a0),
    .mask0_o(m_m0),
    .addr1_o(m_a1),
    .mask1_o(m_m1)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pos_q   <= '0;
      pat_q   <= '0;
      cnt_q   <= '0;
      idx_q   <= '0;
      sel_q   <= 1'b0;
      two_q   <= 1'b0;
      a0_q    <= '0;
      a1_q    <= '0;
      m0_q    <= '0;
      m1_q    <= '0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
      fixed_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            pos_q   <= pos_i;
            pat_q   <= pat_i;
            cnt_q   <= cnt_i;
            idx_q   <= '0;
            fail_q  <= 1'b0;
            fixed_q <= '0;
            state_q <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (cnt_q > CNT_W'(MAX_ERR)) begin
            fail_q  <= 1'b1;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (idx_q == cnt_q) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (m_bad) begin
            fail_q  <= 1'b1;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            two_q   <= m_two;
            a0_q    <= m_a0;
            a1_q    <= m_a1;
            m0_q    <= m_m0;
            m1_q    <= m_m1;
            sel_q   <= 1'b0;
            state_q <= ST_RD;
          end
        end
        ST_RD: state_q <= ST_WR;
        ST_WR: begin
          if (two_q && !sel_q) begin
            sel_q   <= 1'b1;
            state_q <= ST_RD;
          end else begin
            fixed_q <= fixed_q + CNT_W'(1);
            idx_q   <= idx_q + CNT_W'(1);
            state_q <= ST_CHECK;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign raddr_o = sel_q ? a1_q : a0_q;
  assign waddr_o = raddr_o;
  assign we_o    = (state_q == ST_WR);
  assign wdata_o = rdata_i ^ (sel_q ? m1_q : m0_q);
  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;
  assign fail_o  = fail_q;
  assign fixed_o = fixed_q;
endmodule

// File: rtl/sym_corr_apply.sv
module sym_corr_apply
  import sym_corr_pkg::*;
#(
  parameter int DATA_BYTES  = 2048,
  parameter int SPARE_BYTES = 64,
  parameter int MAX_ERR     = 4,
  parameter int LAST_POS    = 1374,
  localparam int DEPTH      = DATA_BYTES + SPARE_BYTES,
  localparam int ADDR_W     = $clog2(DEPTH),
  localparam int POS_W      = $clog2(LAST_POS + 1),
  localparam int CNT_W      = $clog2(MAX_ERR + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       host_we_i,
  input  logic [ADDR_W-1:0]          host_addr_i,
  input  logic [7:0]                 host_wdata_i,
  output logic [7:0]                 host_rdata_o,
  input  logic                       start_i,
  input  logic [CNT_W-1:0]           err_cnt_i,
  input  logic [MAX_ERR*POS_W-1:0]   err_pos_i,
  input  logic [MAX_ERR*SYM_W-1:0]   err_pat_i,
  output logic                       busy_o,
  output logic                       done_o,
  output logic                       fail_o,
  output logic [CNT_W-1:0]           fixed_cnt_o
);
  logic [MAX_ERR-1:0][POS_W-1:0] pos_arr;
  logic [MAX_ERR-1:0][SYM_W-1:0] pat_arr;

  for (genvar i = 0; i < MAX_ERR; i++) begin : g_unpack
    assign pos_arr[i] = err_pos_i[i*POS_W +: POS_W];
    assign pat_arr[i] = err_pat_i[i*SYM_W +: SYM_W];
  end

  logic              seq_busy;
  logic              seq_we;
  logic [ADDR_W-1:0] seq_raddr, seq_waddr;
  logic [7:0]        seq_wdata;
  logic [7:0]        mem_rdata;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_raddr, mem_waddr;
  logic [7:0]        mem_wdata;

  sym_corr_seq #(
    .MAX_ERR (MAX_ERR),
    .POS_W   (POS_W),
    .ADDR_W  (ADDR_W),
    .CNT_W   (CNT_W),
    .LAST_POS(LAST_POS)
  ) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .cnt_i  (err_cnt_i),
    .pos_i  (pos_arr),
    .pat_i  (pat_arr),
    .rdata_i(mem_rdata),
    .raddr_o(seq_raddr),
    .we_o   (seq_we),
    .waddr_o(seq_waddr),
    .wdata_o(seq_wdata),
    .busy_o (seq_busy),
    .done_o (done_o),
    .fail_o (fail_o),
    .fixed_o(fixed_cnt_o)
  );

  // sequencer owns the storage for the whole run
  assign mem_we    = seq_busy ? seq_we    : host_we_i;
  assign mem_waddr = seq_busy ? seq_waddr : host_addr_i;
  assign mem_wdata = seq_busy ? seq_wdata : host_wdata_i;
  assign mem_raddr = seq_busy ? seq_raddr : host_addr_i;

  sym_corr_ram #(
    .DEPTH (DEPTH),
    .ADDR_W(ADDR_W)
  ) u_ram (
    .clk_i  (clk_i),
    .we_i   (mem_we),
    .waddr_i(mem_waddr),
    .wdata_i(mem_wdata),
    .raddr_i(mem_raddr),
    .rdata_o(mem_rdata)
  );

  assign host_rdata_o = mem_rdata;
  assign busy_o       = seq_busy;
endmodule

// File: rtl/sym_corr_apply_chk.sv
module sym_corr_apply_chk #(
  parameter int MAX_ERR = 4,
  parameter int CNT_W   = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [CNT_W-1:0] err_cnt_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             fail_o,
  input logic [CNT_W-1:0] fixed_cnt_o
);
  logic [CNT_W-1:0] cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cap_q <= '0;
    else if (start_i && !busy_o)  cap_q <= err_cnt_i;
  end

  assert_start_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  assert_done_follows_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  assert_done_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(fixed_cnt_o) && $stable(fail_o)));

  assert_full_count_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !fail_o) |-> (fixed_cnt_o == cap_q));

  assert_over_count_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (cap_q > CNT_W'(MAX_ERR))) |-> (fail_o && (fixed_cnt_o == '0)));
endmodule

bind sym_corr_apply sym_corr_apply_chk #(
  .MAX_ERR(MAX_ERR),
  .CNT_W  (CNT_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .err_cnt_i  (err_cnt_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .fail_o     (fail_o),
  .fixed_cnt_o(fixed_cnt_o)
);

// File: tb/sym_corr_apply_bench.sv
module sym_corr_apply_bench;
  localparam int DEPTH = 2112;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        host_we_i = 1'b0;
  logic [11:0] host_addr_i = '0;
  logic [7:0]  host_wdata_i = '0;
  logic [7:0]  host_rdata_o;
  logic        start_i = 1'b0;
  logic [2:0]  err_cnt_i = '0;
  logic [43:0] err_pos_i = '0;
  logic [47:0] err_pat_i = '0;
  logic        busy_o, done_o, fail_o;
  logic [2:0]  fixed_cnt_o;

  always #10 clk_i = ~clk_i;

  sym_corr_apply u_sym_corr_apply (.*);

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] ref_mem [DEPTH];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_wr(input int a, input logic [7:0] d);
    @(negedge clk_i);
    host_we_i = 1'b1; host_addr_i = 12'(a); host_wdata_i = d;
    @(negedge clk_i);
    host_we_i = 1'b0;
  endtask

  task automatic host_rd(input int a, output logic [7:0] d);
    @(negedge clk_i);
    host_addr_i = 12'(a);
    @(negedge clk_i);
    d = host_rdata_o;
  endtask

  task automatic cmp_all(input string req);
    int bad = 0;
    int first = -1;
    logic [7:0] d;
    for (int a = 0; a < DEPTH; a++) begin
      host_rd(a, d);
      if (d !== ref_mem[a]) begin
        bad++;
        if (first < 0) first = a;
      end
    end
    chk(bad == 0, req, bad, 0);
    if (bad != 0) $display("  first differing byte at %0d", first);
  endtask

  // expected effect from the requirements
  task automatic model(input int cnt, input int pos[4], input int pat[4],
                       output bit f, output int fx, output int cyc);
    f = 1'b0; fx = 0; cyc = 0;
    if (cnt > 4) begin f = 1'b1; cyc = 1; return; end
    for (int i = 0; i < cnt; i++) begin
      int p = pos[i];
      int q = pat[i];
      int b = (3 * p) / 2;
      cyc++;
      if (p > 1374) begin f = 1'b1; return; end
      if (p == 0) begin
        if (q > 255) begin f = 1'b1; return; end
        ref_mem[0] ^= 8'(q);
        cyc += 2;
      end else if (p % 2 == 1) begin
        ref_mem[b]   ^= 8'(q >> 4);
        ref_mem[b+1] ^= 8'((q & 15) << 4);
        cyc += 4;
      end else begin
        ref_mem[b-1] ^= 8'(q >> 8);
        ref_mem[b]   ^= 8'(q & 255);
        cyc += 4;
      end
      fx++;
    end
    cyc++;
  endtask

  task automatic run(input int cnt, input int pos[4], input int pat[4],
                     input string req, input bit poke);
    bit ef; int efx, ecyc; int cyc = 0;
    model(cnt, pos, pat, ef, efx, ecyc);
    @(negedge clk_i);
    start_i = 1'b1;
    err_cnt_i = 3'(cnt);
    for (int i = 0; i < 4; i++) begin
      err_pos_i[i*11 +: 11] = 11'(pos[i]);
      err_pat_i[i*12 +: 12] = 12'(pat[i]);
    end
    @(negedge clk_i);
    start_i = 1'b0;
    while (busy_o && cyc < 100) begin
      cyc++;
      if (poke && cyc == 2) begin
        // R11: write attempt and R10: restart attempt during run
        host_we_i = 1'b1; host_addr_i = 12'd10; host_wdata_i = ~ref_mem[10];
        start_i = 1'b1; err_cnt_i = 3'd0;
      end else begin
        host_we_i = 1'b0; start_i = 1'b0;
      end
      @(negedge clk_i);
    end
    host_we_i = 1'b0; start_i = 1'b0;
    chk(cyc == ecyc, {req, " R12 busy cycles"}, cyc, ecyc);
    chk(done_o == 1'b1, {req, " R10 done at end"}, int'(done_o), 1);
    chk(fail_o == ef, {req, " fail flag"}, int'(fail_o), int'(ef));
    chk(int'(fixed_cnt_o) == efx, {req, " R9 fixed count"}, int'(fixed_cnt_o), efx);
    @(negedge clk_i);
    chk(done_o == 1'b0, {req, " R10 done pulse width"}, int'(done_o), 0);
    chk(int'(fixed_cnt_o) == efx && fail_o == ef, {req, " R10 result held"},
        int'(fixed_cnt_o), efx);
    cmp_all({req, " page image"});
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int pz[4], tz[4];
    logic [7:0] d;
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(negedge clk_i);
    chk(busy_o == 0 && done_o == 0 && fail_o == 0 && fixed_cnt_o == 0,
        "R1 reset outputs", {busy_o, done_o, fail_o, fixed_cnt_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(busy_o == 0 && fixed_cnt_o == 0, "R1 after release", int'(busy_o), 0);

    for (int a = 0; a < DEPTH; a++) begin
      logic [7:0] v = 8'($urandom);
      ref_mem[a] = v;
      host_wr(a, v);
    end
    host_wr(2111, 8'h5c); ref_mem[2111] = 8'h5c;
    host_rd(2111, d);
    chk(d == 8'h5c, "R2 last spare byte readback", d, 8'h5c);
    host_rd(0, d);
    chk(d == ref_mem[0], "R2 first byte readback", d, ref_mem[0]);

    pz = '{0, 0, 0, 0}; tz = '{0, 0, 0, 0};
    run(0, pz, tz, "R8 zero pairs", 1'b0);
    run(1, '{0, 0, 0, 0}, '{'h0a5, 0, 0, 0}, "R5 position zero", 1'b0);
    run(1, '{0, 0, 0, 0}, '{'h1a5, 0, 0, 0}, "R5 position zero overflow", 1'b0);
    run(1, '{7, 0, 0, 0}, '{'habc, 0, 0, 0}, "R3 odd position", 1'b0);
    run(1, '{8, 0, 0, 0}, '{'h123, 0, 0, 0}, "R4 even position", 1'b0);
    run(1, '{1365, 0, 0, 0}, '{'hfed, 0, 0, 0}, "R6 straddle", 1'b0);
    run(4, '{1366, 1367, 1373, 1374}, '{'h9a1, 'h3c7, 'h0f0, 'hb0b}, "R7 spare positions", 1'b0);
    run(1, '{1375, 0, 0, 0}, '{'h111, 0, 0, 0}, "R7 out of range", 1'b0);
    run(4, '{5, 6, 2000, 9}, '{'h777, 'h888, 'h999, 'haaa}, "R9 stop at failure R11", 1'b1);
    run(5, '{3, 4, 5, 6}, '{'hfff, 'hfff, 'hfff, 'hfff}, "R8 count above four", 1'b0);
    run(4, '{1, 2, 2, 1}, '{'h5a5, 'h0ff, 'hf00, 'h00f}, "R9 overlapping order", 1'b0);
    run(2, '{1, 0, 0, 0}, '{'h333, 'h0ff, 0, 0}, "R5 zero after odd R3", 1'b0);

    for (int k = 0; k < 12; k++) begin
      int pp[4], tt[4];
      int c = 1 + int'($urandom_range(3));
      for (int i = 0; i < 4; i++) begin
        int r = int'($urandom_range(15));
        if (r == 0)      pp[i] = 1375 + int'($urandom_range(672));
        else if (r == 1) pp[i] = 0;
        else             pp[i] = int'($urandom_range(1374));
        tt[i] = (r == 1 && $urandom_range(1) == 0) ? int'($urandom_range(255))
                                                   : int'($urandom_range(4095));
      end
      run(c, pp, tt, "R3 R4 R9 random set", k[0]);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule